// File: doc/BRIEF.md
# Electronic Shutter Setting Register

This block holds the exposure setting that a sensor timing generator uses for each frame. The setting has two mode bits (called M1 and M2 below) and a 10-bit count. The count means exposed lines or exposed frames, depending on the mode. A select input picks one of two ways to load it:

- **Serial path:** a three-wire port made of a strobe, a shift clock and a data line. It shifts in a 12-bit word.
- **Parallel path:** the two mode pins plus the same three wires act as static levels. They are decoded into a mode and a preset exposure value.

Whichever source is chosen, the active setting changes only on a frame boundary pulse, so an exposure in progress never sees its mode change. Beside the raw mode bits, the block reports an exposure kind (off, lines or frames) to the downstream counters. It also raises a flag when a loaded count is outside the range allowed for its kind.

The serial wires are treated as slow, asynchronous levels. They pass through two synchronizing flops and an edge detector before any shift or capture. The parallel pins are assumed static around the frame pulse and are read directly.

Top module: `shtr_cfg_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the active setting becomes M1=1, M2=1, count 0. In that state `exp_kind`=0 (off) and `cfg_err`=0, and any pending serial word is discarded.
- R2: With `par_sel`=0, each rising edge of `ld_clk` shifts in `ld_data`. A 12-bit word is sent first bit first in this order: M2, M1, then count bit 9 down to bit 0. A rising edge of `ld_strb` captures the last 12 shifted bits as the pending word.
- R3: A pending word appears on `mode_m2`, `mode_m1` and `exp_count` only at the next clock edge where `frame_tick` is high. Between such edges the outputs hold, and each frame pulse retires the pending word.
- R4: `exp_kind` follows the active mode bits. M1=1 and M2=1 gives 0 (off). M1=0 and M2=1 gives 1 (the count is exposed lines). M1=1 and M2=0 gives 2 (the count is exposed frames). M1=0 and M2=0 gives 1.
- R5: A serial word whose M1 and M2 are both 0 is dropped at capture. It never becomes pending, and the next frame pulse leaves the outputs unchanged.
- R6: `cfg_err` is 1 in two cases: the mode is M1=0, M2=1 with a count outside 2..523, or the mode is M1=1, M2=0 with a count outside 2..1022. Otherwise it is 0.
- R7: With `par_sel`=1 and both mode pins low, a frame pulse loads M1=0, M2=0 and count 315. This is the 1/50 s flicker-free exposure in lines.
- R8: With `par_sel`=1, `pin_m1`=0 and `pin_m2`=1, the 3-bit code {`ld_strb`,`ld_clk`,`ld_data`} selects an exposure. Codes 7 down to 0 give 1/60, 1/125, 1/250, 1/500, 1/1000, 1/2000, 1/4000 and 1/10000 s. The loaded line count is 15750/denominator rounded half up, which is 263, 126, 63, 32, 16, 8, 4, 2.
- R9: With `par_sel`=1, `pin_m1`=1 and `pin_m2`=0, a frame pulse loads a frame count of 9 minus the code. Code 7 gives 2 frames and code 0 gives 9 frames.
- R10: With `par_sel`=1 and both mode pins high, a frame pulse loads the off setting: M1=1, M2=1, count 0.
- R11: While `par_sel`=1, activity on the three serial wires neither shifts nor captures. After returning to `par_sel`=0 with nothing pending, a frame pulse leaves the outputs unchanged.
- R12: If a strobe capture and a frame pulse land on the same clock edge, that pulse applies the word that was already pending. The newly captured word stays pending until the following pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_sel | input | 1 | 0: serial loading, 1: parallel decode |
| ld_strb | input | 1 | Serial strobe; parallel code bit 2 |
| ld_clk | input | 1 | Serial shift clock; parallel code bit 1 |
| ld_data | input | 1 | Serial data; parallel code bit 0 |
| pin_m1 | input | 1 | Parallel mode pin M1 |
| pin_m2 | input | 1 | Parallel mode pin M2 |
| frame_tick | input | 1 | Frame boundary pulse, one clock wide |
| mode_m1 | output | 1 | Active mode bit M1 |
| mode_m2 | output | 1 | Active mode bit M2 |
| exp_count | output | 10 | Active count (lines or frames) |
| exp_kind | output | 2 | 0 off, 1 lines, 2 frames |
| cfg_err | output | 1 | Active count out of range for its kind |

## Verification
The two functions that can meet in one clock are the capture of a serial word on a strobe edge and the frame pulse that retires the pending word. The bench provokes this by first leaving one word pending. It then raises the strobe for a second word and counts the two synchronizer stages, so that `frame_tick` is high exactly on the capture edge. It judges the result by reading the outputs after that pulse, which must show the first word. After one further pulse the outputs must show the second word.

// File: rtl/shtr_pkg.sv
// Shared types for the shutter setting register.
// Assumes nothing beyond a 2-bit kind code consumed downstream.
package shtr_pkg;
    typedef enum logic [1:0] {
        KIND_OFF    = 2'd0,
        KIND_LINES  = 2'd1,
        KIND_FRAMES = 2'd2
    } shtr_kind_e;
endpackage

// File: rtl/shtr_serial_rx.sv
// Serial loader: synchronizes strobe/clock/data, shifts on clock rising
// edges and captures the word on a strobe rising edge into a pending slot.
// Assumes the wires are slow, asynchronous levels (several clk per phase).
module shtr_serial_rx #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              strb,
    input  logic              sclk,
    input  logic              sdat,
    input  logic              frame_tick,
    output logic              pend_valid,
    output logic [WORD_W-1:0] pend_word
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] s1_q, s2_q, s3_q;   // {strb, sclk, sdat}
    logic [WORD_W-1:0] sh_q;
    logic              shift_now, cap_now, word_ok;

    // Two-flop synchronizer plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= {strb, sclk, sdat};
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign shift_now = enable && s2_q[1] && !s3_q[1];
    assign cap_now   = enable && s2_q[2] && !s3_q[2];
    assign word_ok   = (sh_q[WORD_W-1:WORD_W-2] != 2'b00);

    // Shift register, first bit ends at the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)         sh_q <= '0;
        else if (shift_now) sh_q <= {sh_q[WORD_W-2:0], s2_q[0]};
    end

    // Pending slot: filled by an accepted capture, retired by a frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_word  <= '0;
        end else if (cap_now && word_ok) begin
            pend_valid <= 1'b1;
            pend_word  <= sh_q;
        end else if (frame_tick) begin
            pend_valid <= 1'b0;
        end
    end

    p_mode00_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_word[WORD_W-1:WORD_W-2] != 2'b00));
    p_pend_retired_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !cap_now) |=> !pend_valid);
    p_quiet_in_parallel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(sh_q) && $stable(pend_word)));
endmodule

// File: rtl/shtr_par_decode.sv
// Parallel decoder: turns the static mode pins and 3-bit code into mode
// bits and a preset count. Line presets are derived from line rate.
// Assumes the pins are stable around the frame pulse.
module shtr_par_decode #(
    parameter int CNT_W           = 10,
    parameter int LINES_PER_FRAME = 525,
    parameter int FRAME_RATE      = 30,
    parameter int FLICKER_RATE    = 50,
    parameter int FRM_BASE        = 9
) (
    input  logic             pm1,
    input  logic             pm2,
    input  logic [2:0]       code,
    output logic             dm1,
    output logic             dm2,
    output logic [CNT_W-1:0] dcnt
);
    localparam int LINE_RATE = LINES_PER_FRAME * FRAME_RATE;

    // Shutter speed denominator for each code (7 slowest, 0 fastest).
    function automatic int speed_den(input logic [2:0] c);
        case (c)
            3'd7: speed_den = 60;
            3'd6: speed_den = 125;
            3'd5: speed_den = 250;
            3'd4: speed_den = 500;
            3'd3: speed_den = 1000;
            3'd2: speed_den = 2000;
            3'd1: speed_den = 4000;
            default: speed_den = 10000;
        endcase
    endfunction

    // Round-half-up line count for an exposure of 1/den seconds.
    function automatic int lines_for(input int den);
        lines_for = (2 * LINE_RATE / den + 1) / 2;
    endfunction

    // Mode pins pass through; the count depends on the decoded mode.
    always_comb begin
        dm1 = pm1;
        dm2 = pm2;
        case ({pm1, pm2})
            2'b00:   dcnt = CNT_W'(lines_for(FLICKER_RATE));
            2'b01:   dcnt = CNT_W'(lines_for(speed_den(code)));
            2'b10:   dcnt = CNT_W'(FRM_BASE - int'(code));
            default: dcnt = '0;
        endcase
    end
endmodule

// File: rtl/shtr_range_chk.sv
// Kind decode and range flag for the active setting.
// Assumes the count is unsigned.
module shtr_range_chk #(
    parameter int CNT_W    = 10,
    parameter int LINE_MIN = 2,
    parameter int LINE_MAX = 523,
    parameter int FRM_MIN  = 2,
    parameter int FRM_MAX  = 1022
) (
    input  logic             m1,
    input  logic             m2,
    input  logic [CNT_W-1:0] cnt,
    output logic [1:0]       kind,
    output logic             err
);
    import shtr_pkg::*;

    localparam logic [CNT_W-1:0] LMIN = CNT_W'(LINE_MIN);
    localparam logic [CNT_W-1:0] LMAX = CNT_W'(LINE_MAX);
    localparam logic [CNT_W-1:0] FMIN = CNT_W'(FRM_MIN);
    localparam logic [CNT_W-1:0] FMAX = CNT_W'(FRM_MAX);

    shtr_kind_e k;

    // Classify the mode and test the count against its window.
    always_comb begin
        case ({m1, m2})
            2'b11:   k = KIND_OFF;
            2'b10:   k = KIND_FRAMES;
            default: k = KIND_LINES;
        endcase
        err = 1'b0;
        if ({m1, m2} == 2'b01) err = (cnt < LMIN) || (cnt > LMAX);
        if ({m1, m2} == 2'b10) err = (cnt < FMIN) || (cnt > FMAX);
    end

    assign kind = k;
endmodule

// File: rtl/shtr_cfg_reg.sv
// Shutter setting register: selects serial or parallel source and updates
// the active mode/count only on a frame pulse.
// Assumes frame_tick is one clock wide.
module shtr_cfg_reg #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_sel,
    input  logic             ld_strb,
    input  logic             ld_clk,
    input  logic             ld_data,
    input  logic             pin_m1,
    input  logic             pin_m2,
    input  logic             frame_tick,
    output logic             mode_m1,
    output logic             mode_m2,
    output logic [CNT_W-1:0] exp_count,
    output logic [1:0]       exp_kind,
    output logic             cfg_err
);
    localparam int WORD_W = CNT_W + 2;

    logic              pend_valid;
    logic [WORD_W-1:0] pend_word;
    logic              dm1, dm2;
    logic [CNT_W-1:0]  dcnt;

    shtr_serial_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .enable(!par_sel),
        .strb(ld_strb), .sclk(ld_clk), .sdat(ld_data),
        .frame_tick(frame_tick),
        .pend_valid(pend_valid), .pend_word(pend_word)
    );

    shtr_par_decode #(.CNT_W(CNT_W)) u_dec (
        .pm1(pin_m1), .pm2(pin_m2), .code({ld_strb, ld_clk, ld_data}),
        .dm1(dm1), .dm2(dm2), .dcnt(dcnt)
    );

    // Active setting: load from the selected source on a frame pulse only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_m1   <= 1'b1;
            mode_m2   <= 1'b1;
            exp_count <= '0;
        end else if (frame_tick) begin
            if (par_sel) begin
                mode_m1   <= dm1;
                mode_m2   <= dm2;
                exp_count <= dcnt;
            end else if (pend_valid) begin
                mode_m2   <= pend_word[WORD_W-1];
                mode_m1   <= pend_word[WORD_W-2];
                exp_count <= pend_word[CNT_W-1:0];
            end
        end
    end

    shtr_range_chk #(.CNT_W(CNT_W)) u_chk (
        .m1(mode_m1), .m2(mode_m2), .cnt(exp_count),
        .kind(exp_kind), .err(cfg_err)
    );

    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> (mode_m1 && mode_m2 && exp_count == '0));
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable({mode_m1, mode_m2, exp_count}));
    p_serial_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !par_sel && pend_valid)
        |=> (exp_count == $past(pend_word[CNT_W-1:0])));
    p_par_mode_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && par_sel)
        |=> (mode_m1 == $past(pin_m1) && mode_m2 == $past(pin_m2)));
endmodule

// File: tb/sim_shtr_cfg_reg.sv
`timescale 1ns/1ps
module sim_shtr_cfg_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic par_sel = 1'b0, ld_strb = 1'b0, ld_clk = 1'b0, ld_data = 1'b0;
    logic pin_m1 = 1'b1, pin_m2 = 1'b1, frame_tick = 1'b0;
    logic mode_m1, mode_m2, cfg_err;
    logic [9:0] exp_count;
    logic [1:0] exp_kind;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    shtr_cfg_reg u0 (
        .clk(clk), .rst_n(rst_n), .par_sel(par_sel),
        .ld_strb(ld_strb), .ld_clk(ld_clk), .ld_data(ld_data),
        .pin_m1(pin_m1), .pin_m2(pin_m2), .frame_tick(frame_tick),
        .mode_m1(mode_m1), .mode_m2(mode_m2), .exp_count(exp_count),
        .exp_kind(exp_kind), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected view of a setting from the requirements.
    task automatic check_set(input string req, input bit m1, input bit m2, input int cnt);
        int kind;
        bit err;
        kind = (m1 && m2) ? 0 : (m1 && !m2) ? 2 : 1;
        err = 0;
        if (!m1 && m2)  err = (cnt < 2) || (cnt > 523);
        if (m1 && !m2)  err = (cnt < 2) || (cnt > 1022);
        check({req, " m1"}, int'(mode_m1), int'(m1));
        check({req, " m2"}, int'(mode_m2), int'(m2));
        check({req, " count"}, int'(exp_count), cnt);
        check({req, " kind"}, int'(exp_kind), kind);
        check({req, " err"}, int'(cfg_err), int'(err));
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
    endtask

    task automatic shift_word(input logic [11:0] w);
        for (int i = 11; i >= 0; i--) begin
            ld_data = w[i];
            wait_clk(3);
            ld_clk = 1'b1;
            wait_clk(4);
            ld_clk = 1'b0;
            wait_clk(2);
        end
    endtask

    task automatic strobe();
        ld_strb = 1'b1;
        wait_clk(4);
        ld_strb = 1'b0;
        wait_clk(4);
    endtask

    function automatic logic [11:0] mkw(input bit m1, input bit m2, input int cnt);
        return {m2, m1, 10'(cnt)};
    endfunction

    function automatic int line_preset(input int code);
        int den;
        case (code)
            7: den = 60;    6: den = 125;   5: den = 250;  4: den = 500;
            3: den = 1000;  2: den = 2000;  1: den = 4000; default: den = 10000;
        endcase
        return (2 * 15750 / den + 1) / 2;
    endfunction

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cm1, cm2, ccnt;
        logic [11:0] words [12];
        words[0]  = mkw(0, 1, 2);    words[1]  = mkw(0, 1, 523);
        words[2]  = mkw(0, 1, 524);  words[3]  = mkw(0, 1, 1);
        words[4]  = mkw(0, 1, 100);  words[5]  = mkw(1, 0, 2);
        words[6]  = mkw(1, 0, 1022); words[7]  = mkw(1, 0, 1023);
        words[8]  = mkw(1, 0, 1);    words[9]  = mkw(1, 1, 5);
        words[10] = mkw(0, 1, 341);  words[11] = mkw(1, 0, 682);

        wait_clk(5);
        check_set("R1 reset", 1, 1, 0);
        rst_n = 1'b1;
        wait_clk(2);

        // R2/R3/R4/R6: serial sweep, hold before tick then apply.
        for (int k = 0; k < 12; k++) begin
            cm1 = mode_m1; cm2 = mode_m2; ccnt = exp_count;
            shift_word(words[k]);
            strobe();
            check_set("R3 hold before tick", cm1[0], cm2[0], ccnt);
            tick();
            check_set("R2 R4 R6 serial applied", words[k][10], words[k][11], int'(words[k][9:0]));
            tick();
            check_set("R3 no pending after retire", words[k][10], words[k][11], int'(words[k][9:0]));
        end

        // R5: mode 00 serial word dropped.
        shift_word(mkw(0, 0, 77));
        strobe();
        tick();
        check_set("R5 mode00 dropped", 1, 0, 682);

        // R7-R10: parallel sweep.
        par_sel = 1'b1;
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 8; c++) begin
                pin_m1 = m[1]; pin_m2 = m[0];
                {ld_strb, ld_clk, ld_data} = 3'(c);
                wait_clk(1);
                tick();
                if (m == 0)      check_set("R7 flickerless", 0, 0, 315);
                else if (m == 1) check_set("R8 fast preset", 0, 1, line_preset(c));
                else if (m == 2) check_set("R9 frame preset", 1, 0, 9 - c);
                else             check_set("R10 off preset", 1, 1, 0);
            end
        end

        // R11: serial activity ignored under parallel select.
        pin_m1 = 1'b0; pin_m2 = 1'b1;
        {ld_strb, ld_clk, ld_data} = 3'b000;
        wait_clk(1);
        tick();
        check_set("R11 parallel base", 0, 1, 2);
        shift_word(mkw(1, 0, 50));
        strobe();
        wait_clk(2);
        par_sel = 1'b0;
        wait_clk(4);
        tick();
        check_set("R11 no capture in parallel", 0, 1, 2);

        // R12: capture and frame pulse on the same edge.
        shift_word(mkw(0, 1, 400));
        strobe();
        shift_word(mkw(1, 0, 30));
        @(negedge clk) ld_strb = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
        check_set("R12 older word applied", 0, 1, 400);
        wait_clk(3);
        ld_strb = 1'b0;
        wait_clk(4);
        tick();
        check_set("R12 new word next pulse", 1, 0, 30);

        // R1: reset clears active and pending.
        shift_word(mkw(0, 1, 9));
        strobe();
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(1);
        check_set("R1 reset again", 1, 1, 0);
        tick();
        check_set("R1 pending cleared", 1, 1, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule